// File: doc/BRIEF.md
# Paged DMA Address and Count Engine

This block is the datapath of one DMA channel. Software loads a 16-bit start address, a 16-bit count holding the number of transfers minus one, an 8-bit page and, optionally, an 8-bit high page. Each accepted transfer strobe does three things. It presents a 32-bit physical address, advances the address by one unit and takes one from the count. The strobe on which the count passes from zero to all-ones is flagged as terminal count.

A parameter picks the channel flavour. A byte channel forms the address as high page, page, address. A word channel moves the address register up one bit, forces bit 0 low and drops page bit 0, so its pages span 128K bytes and its count is in 16-bit words. The address normally wraps inside its page. Writing the high page, which is meant to be the last setup step, lets the wrap carry into the page. A page write takes that permission away again.

With auto-initialise set, terminal count reloads the address and count from copies taken at load time, and the channel stays live. Without it, the channel goes idle until the count is loaded again. A residue output gives the amount still to move: the transfer count for a byte channel, or double it in bytes for a word channel.

Top module: `dma_paged_engine`

## Requirements
- R1: After reset the physical address is 0, the page, high page and address are 0, the channel is idle, the residue is 0 and terminal count is low.
- R2: Register writes use wr_sel_i: 0 loads the address (and its base copy), 1 loads the count (and its base copy) and makes the channel active, 2 loads the page from wr_data_i[7:0], 3 loads the high page from wr_data_i[7:0].
- R3: On a byte channel the physical address is {high_page[7:0], page[7:0], address[15:0]}.
- R4: On a word channel the physical address is {high_page[7:0], page[7:1], address[15:0], 1'b0}. Page bit 0 has no effect on it.
- R5: Each strobe accepted while active raises the address by one and lowers the count by one.
- R6: A count load of L gives L+1 accepted strobes. tc_o is high during the strobe that finds the count at 0, so a load of 0 gives terminal count on the first strobe.
- R7: Until the high page has been written, the address wraps from 0xFFFF to 0x0000 and the page and high page stay unchanged.
- R8: Once the high page has been written, a wrap adds one to the page number. The page number is {high_page, page} on a byte channel and {high_page, page[7:1]} on a word channel, and the carry runs into the high page.
- R9: A page write clears the carry permission, so a later wrap stays inside the page until the high page is written again.
- R10: The residue is (count + 1) mod 65536 for a byte channel and twice that, 17 bits wide, for a word channel.
- R11: Without auto-initialise, terminal count makes the channel idle. Later strobes then leave the address and count unchanged and raise no terminal count.
- R12: With auto_init_i high, terminal count reloads the address and count from their base copies and the channel stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 address, 1 count, 2 page, 3 high page |
| wr_data_i | input | 16 | Write data; the page registers take bits 7:0 |
| auto_init_i | input | 1 | Reload address and count at terminal count |
| xfer_i | input | 1 | Transfer strobe, one per clock |
| phys_addr_o | output | 32 | Physical address of the current transfer |
| tc_o | output | 1 | Terminal count, high with the final strobe |
| active_o | output | 1 | Channel accepts strobes |
| residue_o | output | 17 | Amount left to transfer, in bytes |

## Verification
The hardest case to reach is a wrap of the address at the moment carry permission is active. The checks need the page to be at 0xFF, so that the carry ripples into the high page. They also need a page write to have withdrawn the permission before the next wrap. The stimulus sets this up by loading the address at 0xFFFF, writing the high page last, and stepping once. It then rewrites the page and repeats the wrap. Byte and word instances run side by side on the same inputs, so each page pattern is compared against both address layouts.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_PAGE   = 2'd2,
    SEL_HIPAGE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         step_i,
  input  logic         reload_i,
  output logic [W-1:0] cur_o,
  output logic         wrap_o
);
  logic [W-1:0] base_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (ld_i) begin
      base_q <= ld_val_i;
      cur_q  <= ld_val_i;
    end else if (step_i) begin
      cur_q <= reload_i ? base_q : cur_q + 1'b1;
    end
  end

  assign cur_o  = cur_q;
  assign wrap_o = step_i & ~reload_i & ~ld_i & (&cur_q);

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_i && !reload_i) |=> cur_q == W'($past(cur_q) + 1'b1)); // R5
  AST_ADDR_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_i && reload_i) |=> cur_q == $past(base_q)); // R12
endmodule

// File: rtl/dma_count_ctr.sv
module dma_count_ctr #(
  parameter int W       = 16,
  parameter bit WORD_CH = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         step_i,
  input  logic         reload_i,
  output logic         zero_o,
  output logic [W:0]   residue_o
);
  logic [W-1:0] base_q, cnt_q, left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '1;
      cnt_q  <= '1;
    end else if (ld_i) begin
      base_q <= ld_val_i;
      cnt_q  <= ld_val_i;
    end else if (step_i) begin
      cnt_q <= reload_i ? base_q : cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
  assign left   = cnt_q + 1'b1;

  generate
    if (WORD_CH) begin : g_word
      assign residue_o = {left, 1'b0};
    end else begin : g_byte
      assign residue_o = {1'b0, left};
    end
  endgenerate

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_i && !reload_i) |=> cnt_q == W'($past(cnt_q) - 1'b1)); // R5
  AST_CNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_i && reload_i) |=> cnt_q == $past(base_q)); // R12
endmodule

// File: rtl/dma_page_regs.sv
module dma_page_regs #(
  parameter int PW      = 8,
  parameter int HW      = 8,
  parameter bit WORD_CH = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pg_wr_i,
  input  logic          hp_wr_i,
  input  logic [PW-1:0] data_i,
  input  logic          wrap_i,
  output logic [PW-1:0] page_o,
  output logic [HW-1:0] hipage_o,
  output logic          hi_en_o
);
  logic [PW-1:0] pg_q;
  logic [HW-1:0] hp_q;
  logic          en_q;
  logic [PW-1:0] pg_inc;
  logic [HW-1:0] hp_inc;

  generate
    if (WORD_CH) begin : g_word
      assign {hp_inc, pg_inc[PW-1:1]} = {hp_q, pg_q[PW-1:1]} + 1'b1;
      assign pg_inc[0] = pg_q[0];
    end else begin : g_byte
      assign {hp_inc, pg_inc} = {hp_q, pg_q} + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q <= '0;
      hp_q <= '0;
      en_q <= 1'b0;
    end else if (pg_wr_i) begin
      pg_q <= data_i;
      en_q <= 1'b0;
    end else if (hp_wr_i) begin
      hp_q <= data_i[HW-1:0];
      en_q <= 1'b1;
    end else if (wrap_i && en_q) begin
      pg_q <= pg_inc;
      hp_q <= hp_inc;
    end
  end

  assign page_o   = pg_q;
  assign hipage_o = hp_q;
  assign hi_en_o  = en_q;

  AST_NO_CARRY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !pg_wr_i && !hp_wr_i) |=> ($stable(pg_q) && $stable(hp_q))); // R7
  AST_PAGE_CLR_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_wr_i |=> !en_q); // R9
endmodule

// File: rtl/dma_paged_engine.sv
module dma_paged_engine
  import dma_eng_pkg::*;
#(
  parameter bit WORD_CH = 1'b0,
  parameter int W       = 16,
  parameter int PAGE_W  = 8,
  parameter int HIPG_W  = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [1:0]                  wr_sel_i,
  input  logic [W-1:0]                wr_data_i,
  input  logic                        auto_init_i,
  input  logic                        xfer_i,
  output logic [HIPG_W+PAGE_W+W-1:0]  phys_addr_o,
  output logic                        tc_o,
  output logic                        active_o,
  output logic [W:0]                  residue_o
);
  logic          ld_addr, ld_cnt, wr_pg, wr_hp;
  logic          step, tc, reload, cnt_zero, wrap, hi_en;
  logic          active_q;
  logic [W-1:0]  addr;
  logic [PAGE_W-1:0] page;
  logic [HIPG_W-1:0] hipage;

  assign ld_addr = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_ADDR);
  assign ld_cnt  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_COUNT);
  assign wr_pg   = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_PAGE);
  assign wr_hp   = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_HIPAGE);

  assign step   = xfer_i & active_q;
  assign tc     = step & cnt_zero;
  assign reload = tc & auto_init_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 active_q <= 1'b0;
    else if (ld_cnt)             active_q <= 1'b1;
    else if (tc && !auto_init_i) active_q <= 1'b0;
  end

  dma_addr_ctr #(.W(W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld_addr),
    .ld_val_i (wr_data_i),
    .step_i   (step),
    .reload_i (reload),
    .cur_o    (addr),
    .wrap_o   (wrap)
  );

  dma_count_ctr #(.W(W), .WORD_CH(WORD_CH)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld_cnt),
    .ld_val_i  (wr_data_i),
    .step_i    (step),
    .reload_i  (reload),
    .zero_o    (cnt_zero),
    .residue_o (residue_o)
  );

  dma_page_regs #(.PW(PAGE_W), .HW(HIPG_W), .WORD_CH(WORD_CH)) u_page (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pg_wr_i  (wr_pg),
    .hp_wr_i  (wr_hp),
    .data_i   (wr_data_i[PAGE_W-1:0]),
    .wrap_i   (wrap),
    .page_o   (page),
    .hipage_o (hipage),
    .hi_en_o  (hi_en)
  );

  generate
    if (WORD_CH) begin : g_word
      assign phys_addr_o = {hipage, page[PAGE_W-1:1], addr, 1'b0};
    end else begin : g_byte
      assign phys_addr_o = {hipage, page, addr};
    end
  endgenerate

  assign tc_o     = tc;
  assign active_o = active_q;

  AST_IDLE_AFTER_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && !auto_init_i && !ld_cnt) |=> !active_q); // R11
  AST_STAY_ON_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && auto_init_i) |=> active_q); // R12
  AST_CARRY_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !hi_en && !wr_pg && !wr_hp) |=> $stable(page)); // R7
endmodule

// File: tb/sim_dma_paged_engine.sv
`timescale 1ns/1ps
module sim_dma_paged_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        auto_init = 1'b0;
  logic        xfer = 1'b0;
  logic [31:0] pa0, pa1;
  logic        tc0, tc1, act0, act1;
  logic [16:0] res0, res1;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_paged_engine #(.WORD_CH(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .auto_init_i(auto_init), .xfer_i(xfer),
    .phys_addr_o(pa0), .tc_o(tc0), .active_o(act0), .residue_o(res0));

  dma_paged_engine #(.WORD_CH(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .auto_init_i(auto_init), .xfer_i(xfer),
    .phys_addr_o(pa1), .tc_o(tc1), .active_o(act1), .residue_o(res1));

  // page, address, byte-channel physical, word-channel physical
  localparam logic [87:0] VEC [4] = '{
    {8'h13, 16'h3456, 32'h0013_3456, 32'h0012_68AC},
    {8'hFF, 16'hFFFF, 32'h00FF_FFFF, 32'h00FF_FFFE},
    {8'h00, 16'h0001, 32'h0000_0001, 32'h0000_0002},
    {8'h80, 16'h8000, 32'h0080_8000, 32'h0081_0000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(output logic t0, output logic t1);
    @(negedge clk);
    xfer = 1'b1;
    #1;
    t0 = tc0; t1 = tc1;
    @(negedge clk);
    xfer = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic t0, t1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pa byte", pa0, 32'h0);
    chk("R1 pa word", pa1, 32'h0);
    chk("R1 active", {30'd0, act0, act1}, 32'h0);
    chk("R1 residue", {15'd0, res0}, 32'h0);
    chk("R1 tc", {30'd0, tc0, tc1}, 32'h0);
    rst_n = 1'b1;

    // R2 R3 R4 composition table
    for (int i = 0; i < 4; i++) begin
      wr(2'd2, {8'h00, VEC[i][87:80]});
      wr(2'd0, VEC[i][79:64]);
      #1;
      chk("R3 byte compose", pa0, VEC[i][63:32]);
      chk("R4 word compose", pa1, VEC[i][31:0]);
    end

    // R6 R7 R10: count 2 -> three transfers, wrap stays in page
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'hFFFE);
    wr(2'd1, 16'h0002);
    #1;
    chk("R2 active after count load", {31'd0, act0}, 32'd1);
    chk("R10 byte residue", {15'd0, res0}, 32'd3);
    chk("R10 word residue", {15'd0, res1}, 32'd6);
    step(t0, t1);
    chk("R6 no tc first", {31'd0, t0}, 32'd0);
    chk("R5 addr step", pa0, 32'h0005_FFFF);
    chk("R10 residue after step", {15'd0, res0}, 32'd2);
    step(t0, t1);
    chk("R7 wrap in page byte", pa0, 32'h0005_0000);
    chk("R7 wrap in page word", pa1, 32'h0004_0000);
    chk("R6 no tc second", {31'd0, t0}, 32'd0);
    step(t0, t1);
    chk("R6 tc on last", {30'd0, t0, t1}, 32'd3);
    chk("R11 idle", {30'd0, act0, act1}, 32'd0);
    chk("R10 residue zero", {15'd0, res0}, 32'd0);
    step(t0, t1);
    chk("R11 ignored tc", {30'd0, t0, t1}, 32'd0);
    chk("R11 ignored addr", pa0, 32'h0005_0001);

    // R8 carry with high page written last
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0001);
    wr(2'd3, 16'h00A7);
    #1;
    chk("R3 hipage byte", pa0, 32'hA705_FFFF);
    chk("R4 hipage word", pa1, 32'hA705_FFFE);
    step(t0, t1);
    chk("R8 carry byte", pa0, 32'hA706_0000);
    chk("R8 carry word", pa1, 32'hA706_0000);

    // R8 carry rippling into high page; R6 load of 0 is one transfer
    wr(2'd2, 16'h00FF);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h0010);
    step(t0, t1);
    chk("R6 tc on single", {30'd0, t0, t1}, 32'd3);
    chk("R8 ripple byte", pa0, 32'h1100_0000);
    chk("R8 ripple word", pa1, 32'h1100_0000);

    // R9 page write withdraws carry
    wr(2'd2, 16'h0020);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0000);
    step(t0, t1);
    chk("R9 no carry byte", pa0, 32'h1120_0000);
    chk("R9 no carry word", pa1, 32'h1120_0000);

    // R12 auto-initialise
    auto_init = 1'b1;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h1000);
    wr(2'd1, 16'h0001);
    step(t0, t1);
    chk("R5 auto step", pa0, 32'h1100_1001);
    step(t0, t1);
    chk("R12 tc", {30'd0, t0, t1}, 32'd3);
    chk("R12 reload byte", pa0, 32'h1100_1000);
    chk("R12 reload word", pa1, 32'h1100_2000);
    chk("R12 still active", {30'd0, act0, act1}, 32'd3);
    chk("R12 count reloaded", {15'd0, res0}, 32'd2);
    auto_init = 1'b0;

    // R10 residue extremes
    wr(2'd1, 16'hFFFF);
    #1;
    chk("R10 wrap byte", {15'd0, res0}, 32'd0);
    chk("R10 wrap word", {15'd0, res1}, 32'd0);
    wr(2'd1, 16'h7FFF);
    #1;
    chk("R10 mid byte", {15'd0, res0}, 32'h0000_8000);
    chk("R10 mid word", {15'd0, res1}, 32'h0001_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule